// File: doc/BRIEF.md
# Software-Driven I2C Pin Register

This peripheral gives software direct control of the two wires of an I2C bus. A two-bit pin latch holds the requested level of the clock line (bit 0) and the data line (bit 1). Software raises latch bits through one register address and lowers them through another, so it never needs a read-modify-write. Each latch bit drives an open-drain output enable. A latch bit of 0 asserts the enable and pulls the wire low. A latch bit of 1 releases the wire, and an external pull-up then holds it high. The block has no protocol sequencing and no clock generation: software times every edge of start, data, acknowledge and stop.

The data wire is sensed through a synchronizer. A status read returns the clock bit software last wrote, next to the synchronized level of the data wire. That level is the wired-AND of every device on the bus, so an acknowledge from a target shows up there. The register port is a single-cycle slave interface with no wait states. It has select, write enable, a byte address inside a 4 KiB window, a write word and a combinational read word. There is no data stream, so there is no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented.

Top module: `bbi2c_pin_reg`

## Requirements
- R1: After reset, the pin latch is 0b11 and both output enables are low. For the first two clock edges after reset is released, a read of offset 0x0 returns 0.
- R2: A write to offset 0x0 ORs write-data bits [1:0] into the latch (bit 0 is the clock, bit 1 is the data). The new value is in place after the write's clock edge.
- R3: A write to offset 0x4 clears each latch bit whose write-data bit is 1. Write-data bits above bit 1 have no effect on offset 0x0 or on offset 0x4.
- R4: The clock output enable equals the inverse of latch bit 0, and the data output enable equals the inverse of latch bit 1. A 1 on an enable pulls its wire low.
- R5: Once the block has settled, a read of offset 0x0 returns the clock latch bit in bit 0 and the synchronized data-wire level in bit 1. Bits 31 to 2 read as 0.
- R6: A change on the sensed data input appears in read bit 1 after exactly two rising clock edges.
- R7: A read of any offset in the 4 KiB window other than 0x0 returns 0xFFFFFFFF. Reads never change the latch.
- R8: A write to any offset other than 0x0 and 0x4 leaves the latch and both output enables unchanged.
- R9: Bus-driven data is visible through the read path. While the latch releases the data wire and a target holds the wire low, read bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Access strobe, one cycle per access |
| wr_en_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset inside the 4 KiB window |
| wdata_i | input | 32 | Write word |
| rdata_o | output | 32 | Read word, combinational, valid while sel_i is high and wr_en_i is low |
| sda_i | input | 1 | Sensed level of the data wire |
| scl_oe_o | output | 1 | Pull clock wire low when 1 |
| sda_oe_o | output | 1 | Pull data wire low when 1 |

## Verification
A write takes effect on the clock edge that accepts it. The output enables therefore change after that one edge, and the bench samples them at the following falling edge. A change on the sensed data line takes two rising edges to reach the read word. The bench checks that boundary directly: it samples once after one edge, expecting the old value, and again after two, expecting the new one. Every other status read is issued at least three edges after the last write or bus change, so the value is settled when the bench compares it. Reads are combinational, so the bench samples them in the same cycle it presents the address.

// File: rtl/bbi2c_pkg.sv
package bbi2c_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PIN_N    = 2;
  localparam int unsigned PIN_SCL  = 0;
  localparam int unsigned PIN_SDA  = 1;
  localparam logic [ADDR_W-1:0] OFS_SET = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CLR = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_STS = 12'h000;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } latch_op_e;
endpackage

// File: rtl/bbi2c_addr_dec.sv
module bbi2c_addr_dec
  import bbi2c_pkg::*;
(
  input  logic              sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output latch_op_e         op_o,
  output logic              rd_sts_o,
  output logic              rd_bad_o
);
  always_comb begin
    op_o     = OP_NONE;
    rd_sts_o = 1'b0;
    rd_bad_o = 1'b0;
    if (sel_i && wr_en_i) begin
      if (addr_i == OFS_SET)      op_o = OP_SET;
      else if (addr_i == OFS_CLR) op_o = OP_CLR;
    end else if (sel_i) begin
      if (addr_i == OFS_STS) rd_sts_o = 1'b1;
      else                   rd_bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/bbi2c_pin_latch.sv
module bbi2c_pin_latch
  import bbi2c_pkg::*;
#(
  parameter int unsigned N = PIN_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  latch_op_e    op_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] latch_o
);
  logic [N-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '1;
    else begin
      unique case (op_i)
        OP_SET:  latch_q <= latch_q | bits_i;
        OP_CLR:  latch_q <= latch_q & ~bits_i;
        default: latch_q <= latch_q;
      endcase
    end
  end
  assign latch_o = latch_q;

  assert_set_or_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SET) |=> (latch_q == ($past(latch_q) | $past(bits_i))));
  assert_clr_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLR) |=> (latch_q == ($past(latch_q) & ~$past(bits_i))));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NONE) |=> $stable(latch_q));
endmodule

// File: rtl/bbi2c_sync.sv
module bbi2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic dout_o,
  output logic settled_o
);
  localparam int unsigned CW = $clog2(STAGES + 1);
  logic [STAGES-1:0] stage_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= 1'b0;
    else         stage_q[0] <= din_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= 1'b0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (cnt_q != CW'(STAGES))     cnt_q <= cnt_q + 1'b1;
  end

  assign dout_o    = stage_q[STAGES-1];
  assign settled_o = (cnt_q == CW'(STAGES));

  generate
    if (STAGES == 2) begin : g_chk
      assert_sync_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        settled_o |-> (dout_o == $past(din_i, 2)));
    end
  endgenerate
  assert_settle_mono_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled_o |=> settled_o);
endmodule

// File: rtl/bbi2c_rd_mux.sv
module bbi2c_rd_mux
  import bbi2c_pkg::*;
(
  input  logic              rd_sts_i,
  input  logic              rd_bad_i,
  input  logic              settled_i,
  input  logic              scl_bit_i,
  input  logic              sda_sense_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_bad_i)
      rdata_o = '1;
    else if (rd_sts_i && settled_i) begin
      rdata_o[PIN_SCL] = scl_bit_i;
      rdata_o[PIN_SDA] = sda_sense_i;
    end
  end
endmodule

// File: rtl/bbi2c_pin_reg.sv
module bbi2c_pin_reg
  import bbi2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  latch_op_e         op;
  logic              rd_sts, rd_bad, settled, sda_sense;
  logic [PIN_N-1:0]  latch;

  bbi2c_addr_dec u_dec (
    .sel_i   (sel_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .op_o    (op),
    .rd_sts_o(rd_sts),
    .rd_bad_o(rd_bad)
  );

  bbi2c_pin_latch #(.N(PIN_N)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .bits_i (wdata_i[PIN_N-1:0]),
    .latch_o(latch)
  );

  bbi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .din_i    (sda_i),
    .dout_o   (sda_sense),
    .settled_o(settled)
  );

  bbi2c_rd_mux u_rd (
    .rd_sts_i   (rd_sts),
    .rd_bad_i   (rd_bad),
    .settled_i  (settled),
    .scl_bit_i  (latch[PIN_SCL]),
    .sda_sense_i(sda_sense),
    .rdata_o    (rdata_o)
  );

  assign scl_oe_o = ~latch[PIN_SCL];
  assign sda_oe_o = ~latch[PIN_SDA];

  assert_sts_scl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_en_i && addr_i == OFS_STS && settled) |-> (rdata_o[0] == !scl_oe_o));
  assert_sts_high_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_en_i && addr_i == OFS_STS) |-> (rdata_o[DATA_W-1:2] == '0));
  assert_bad_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_en_i && addr_i != OFS_STS) |-> (&rdata_o));
  assert_read_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_en_i) |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));
  assert_bad_wr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_en_i && addr_i != OFS_SET && addr_i != OFS_CLR)
      |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));
  assert_high_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_en_i && wdata_i[1:0] == 2'b00 && (|wdata_i))
      |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));
  assert_unsettled_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!settled && sel_i && !wr_en_i && addr_i == OFS_STS) |-> (rdata_o == '0));
endmodule

// File: tb/bbi2c_pin_reg_tb_top.sv
module bbi2c_pin_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        scl_oe, sda_oe;
  logic        slave_pull = 1'b0, ext_pull = 1'b0, slave_en = 1'b0;
  logic        started = 1'b0;
  int          bitcnt = 0;
  logic        scl_line, sda_line;
  logic [1:0]  lm;
  int          checks = 0, errors = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slave_pull | ext_pull);

  bbi2c_pin_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // open-drain target: acknowledges the ninth clock after a start
  always @(negedge sda_line) if (slave_en && scl_line) begin started = 1'b1; bitcnt = 0; end
  always @(posedge scl_line) if (slave_en && started) bitcnt = bitcnt + 1;
  always @(negedge scl_line) if (slave_en && started) begin
    if (bitcnt == 8) slave_pull = 1'b1;
    else if (bitcnt == 9) begin slave_pull = 1'b0; started = 1'b0; end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_acc(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
    if (a == 12'h000) lm = lm | d[1:0];
    else if (a == 12'h004) lm = lm & ~d[1:0];
  endtask

  task automatic rd_acc(input logic [11:0] a, input int wait_cyc, output logic [31:0] v);
    repeat (wait_cyc) @(negedge clk);
    sel = 1; wr = 0; addr = a; #1 v = rdata;
    @(negedge clk); sel = 0;
  endtask

  function automatic logic [31:0] sts_exp();
    return {30'd0, lm[1] & ~slave_pull & ~ext_pull, lm[0]};
  endfunction

  task automatic pins_chk(input string req);
    chk(req, {30'd0, sda_oe, scl_oe}, {30'd0, ~lm[1], ~lm[0]});
  endtask

  task automatic sts_chk(input string req);
    rd_acc(12'h000, 3, rv);
    chk(req, rv, sts_exp());
  endtask

  initial begin
    lm = 2'b11;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state and unsettled read
    sel = 1; wr = 0; addr = 12'h000; #1;
    chk("R1 unsettled read", rdata, 32'h0);
    chk("R1 reset enables", {30'd0, sda_oe, scl_oe}, 32'h0);
    @(negedge clk);
    chk("R1 unsettled read 2", rdata, 32'h0);
    sel = 0;
    sts_chk("R1 settled reset status");

    // R2/R3/R4: exhaustive latch start value x write data
    for (int v = 0; v < 4; v++) begin
      for (int d = 0; d < 4; d++) begin
        wr_acc(12'h004, 32'h3); wr_acc(12'h000, v);
        wr_acc(12'h000, d);
        pins_chk("R4 enables after set");
        chk("R2 set result", {30'd0, ~sda_oe, ~scl_oe}, 32'(v | d));
        sts_chk("R5 status after set");
        wr_acc(12'h004, 32'h3); wr_acc(12'h000, v);
        wr_acc(12'h004, d);
        chk("R3 clear result", {30'd0, ~sda_oe, ~scl_oe}, 32'(v & ~d & 3));
        sts_chk("R5 status after clear");
      end
    end

    // R3: high bits ignored
    wr_acc(12'h004, 32'h3); wr_acc(12'h000, 32'h1);
    wr_acc(12'h000, 32'hFFFF_FFFC);
    pins_chk("R3 high bits set ignored");
    wr_acc(12'h004, 32'hFFFF_FFFC);
    pins_chk("R3 high bits clear ignored");
    chk("R3 latch still 01", {30'd0, ~sda_oe, ~scl_oe}, 32'h1);

    // R7: other offsets read all ones, no side effect
    foreach (rv[i]) ;
    begin
      logic [11:0] offs [4] = '{12'h004, 12'h008, 12'h800, 12'hFFC};
      for (int i = 0; i < 4; i++) begin
        rd_acc(offs[i], 0, rv);
        chk("R7 bad offset read", rv, 32'hFFFF_FFFF);
      end
      pins_chk("R7 reads leave latch");
      // R8: unsupported writes
      for (int i = 1; i < 4; i++) begin
        wr_acc(offs[i], 32'hFFFF_FFFF);
        pins_chk("R8 bad offset write");
      end
      sts_chk("R8 status after bad writes");
    end

    // R6: exact two-edge latency of sensed data
    wr_acc(12'h000, 32'h3);
    repeat (3) @(negedge clk);
    ext_pull = 1'b1;
    @(negedge clk);
    sel = 1; wr = 0; addr = 12'h000; #1;
    chk("R6 one edge old value", rdata, 32'h3);
    @(negedge clk); #1;
    chk("R6 two edges new value", rdata, 32'h1);
    sel = 0;
    ext_pull = 1'b0;
    sts_chk("R6 release seen");

    // R9: software-driven start, address byte 0xA0, ack, stop
    slave_en = 1'b1;
    wr_acc(12'h000, 32'h3);
    sts_chk("R5 idle bus");
    wr_acc(12'h004, 32'h2); sts_chk("R5 start sda low");
    wr_acc(12'h004, 32'h1); sts_chk("R5 start scl low");
    for (int b = 7; b >= 0; b--) begin
      if (((8'hA0 >> b) & 1) != 0) wr_acc(12'h000, 32'h2);
      else                         wr_acc(12'h004, 32'h2);
      wr_acc(12'h000, 32'h1);
      sts_chk("R5 address bit");
      wr_acc(12'h004, 32'h1);
    end
    wr_acc(12'h000, 32'h2);
    sts_chk("R9 ack phase scl low");
    wr_acc(12'h000, 32'h1);
    rd_acc(12'h000, 3, rv);
    chk("R9 ack seen low", rv, 32'h1);
    chk("R9 ack model", rv, sts_exp());
    wr_acc(12'h004, 32'h1);
    sts_chk("R9 target released");
    wr_acc(12'h004, 32'h2);
    wr_acc(12'h000, 32'h1); sts_chk("R5 stop scl high");
    wr_acc(12'h000, 32'h2); sts_chk("R5 stop sda high");
    pins_chk("R4 bus idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule